// File: doc/BRIEF.md
# Character Row Text Renderer

This block paints one horizontal strip of text, white on black, at a fixed place on a 640x480 display. It does not make sync pulses or count pixels itself: an external timing generator supplies the horizontal and vertical pixel counters. For each counter pair the block works out whether the pixel lies inside the text strip. If it does, the block looks up the character that sits under that pixel, picks the matching pixel of that character's glyph, and registers an 8-bit colour in 3-3-2 form on the pixel clock.

The characters come from a small buffer of 6-bit codes that is written through a plain port: an address, a code and a write enable. Each character cell is 7 pixels wide and 8 pixels tall. The glyph lookup is built into the block. The horizontal counter must advance by one on every clock while it crosses the strip. Because of this, the character slot and the column inside the cell are stepped by a small counter that wraps at seven, so no divider is needed.

Top module: `char_row_render`

## Requirements
- R1: A glyph is seven 8-bit column words. Bit j of column word c lights row j of cell column c, where row 0 is the top line of the strip. A cell occupies 7 columns by 8 rows.
- R2: Cell columns 0 and 6 are always dark for every code. This leaves a one-pixel gap between neighbouring characters.
- R3: Codes 0 to 9 show the digits '0' to '9', and codes 10 to 35 show 'A' to 'Z' in order. Columns 1 to 5 of some glyphs, in hex: '1' = 00 42 7F 40 00, 'A' = 7E 11 11 11 7E, 'H' = 7F 08 08 08 7F, 'L' = 7F 40 40 40 40.
- R4: Code 62 is an empty cell, and code 63 is a colon with columns 1 to 5 = 00 36 36 00 00. Every other code from 36 to 61 shows an asterisk with columns 1 to 5 = 14 08 3E 08 14.
- R5: Whenever the counters lie outside the visible window (vertical 31 to 510, horizontal 144 to 783, both ends included), the colour is 8'h00, even where a glyph bit is set.
- R6: Inside the strip and inside the visible window, a set glyph bit gives full white {red,grn,blu} = 8'hFF, and a clear bit gives 8'h00. The strip starts at column BOX_LEFT + 7*slot + col and row BOX_TOP + row.
- R7: A visible pixel outside the strip (horizontal BOX_LEFT to BOX_LEFT+7*N_CHARS-1, vertical BOX_TOP to BOX_TOP+7) is 8'h00.
- R8: The colour for the counters presented in one cycle appears after that cycle's rising clock edge. An active-low reset forces the colour to 8'h00 at once and holds it there. Reset is released in step with the clock.
- R9: A write to slot k changes the pixels that are presented from the next clock cycle onward. A pixel presented in the same cycle as the write still uses the old code. A write address of N_CHARS or above changes nothing. After reset every slot holds code 62.
- R10: The slot and cell column restart at the strip's left edge on every line. This stays correct on any line, provided the horizontal counter advances by one per clock across the strip.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| h_cnt | input | CNT_W | Horizontal pixel counter from the timing generator |
| v_cnt | input | CNT_W | Vertical line counter from the timing generator |
| wr_en | input | 1 | Write strobe for the code buffer |
| wr_addr | input | ADDR_W | Slot to write |
| wr_code | input | 6 | Character code to store |
| red | output | 3 | Red level |
| grn | output | 3 | Green level |
| blu | output | 2 | Blue level |

## Verification
The bench places the strip so that it straddles the top-left corner of the visible window. Part of one glyph then falls in the blanked border, and a design that skipped the window test would show lit pixels there. It checks pixels in both gap columns and in both kinds of unused code: a wrong bit order or column order would flip individual pixels, and a missing asterisk default would leave those cells empty. It writes a slot in the very cycle one of its pixels is shown, then writes out-of-range addresses. A design with the wrong write timing would show the new glyph one pixel early or late, and one that truncated the address would corrupt a visible slot. It also scans many lines one after another, so a column stepper that failed to restart at the left edge would shift every later line.

// File: rtl/crr_pkg.sv
package crr_pkg;

  localparam int GLYPH_W = 7;
  localparam int GLYPH_H = 8;
  localparam int CODE_W  = 6;

  localparam logic [CODE_W-1:0] CODE_BLANK = 6'd62;
  localparam logic [CODE_W-1:0] CODE_COLON = 6'd63;

  typedef logic [CODE_W-1:0] char_code_t;
  typedef logic [2:0]        cell_col_t;
  typedef logic [2:0]        cell_row_t;

  // Inner five columns of a glyph, column 1 in the top byte.
  // Bit 0 of each byte is the top row of the cell.
  function automatic logic [39:0] glyph_body(input char_code_t code);
    logic [39:0] body;
    case (code)
      6'd0:  body = 40'h3E_51_49_45_3E;
      6'd1:  body = 40'h00_42_7F_40_00;
      6'd2:  body = 40'h42_61_51_49_46;
      6'd3:  body = 40'h21_41_45_4B_31;
      6'd4:  body = 40'h18_14_12_7F_10;
      6'd5:  body = 40'h27_45_45_45_39;
      6'd6:  body = 40'h3C_4A_49_49_30;
      6'd7:  body = 40'h01_71_09_05_03;
      6'd8:  body = 40'h36_49_49_49_36;
      6'd9:  body = 40'h06_49_49_29_1E;
      6'd10: body = 40'h7E_11_11_11_7E;
      6'd11: body = 40'h7F_49_49_49_36;
      6'd12: body = 40'h3E_41_41_41_22;
      6'd13: body = 40'h7F_41_41_22_1C;
      6'd14: body = 40'h7F_49_49_49_41;
      6'd15: body = 40'h7F_09_09_01_01;
      6'd16: body = 40'h3E_41_41_51_32;
      6'd17: body = 40'h7F_08_08_08_7F;
      6'd18: body = 40'h00_41_7F_41_00;
      6'd19: body = 40'h20_40_41_3F_01;
      6'd20: body = 40'h7F_08_14_22_41;
      6'd21: body = 40'h7F_40_40_40_40;
      6'd22: body = 40'h7F_02_04_02_7F;
      6'd23: body = 40'h7F_04_08_10_7F;
      6'd24: body = 40'h3E_41_41_41_3E;
      6'd25: body = 40'h7F_09_09_09_06;
      6'd26: body = 40'h3E_41_51_21_5E;
      6'd27: body = 40'h7F_09_19_29_46;
      6'd28: body = 40'h46_49_49_49_31;
      6'd29: body = 40'h01_01_7F_01_01;
      6'd30: body = 40'h3F_40_40_40_3F;
      6'd31: body = 40'h1F_20_40_20_1F;
      6'd32: body = 40'h7F_20_18_20_7F;
      6'd33: body = 40'h63_14_08_14_63;
      6'd34: body = 40'h03_04_78_04_03;
      6'd35: body = 40'h61_51_49_45_43;
      CODE_BLANK: body = 40'h00_00_00_00_00;
      CODE_COLON: body = 40'h00_36_36_00_00;
      default:    body = 40'h14_08_3E_08_14;
    endcase
    return body;
  endfunction

endpackage

// File: rtl/crr_reset_sync.sv
module crr_reset_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_core_n
);

  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_core_n = sync_q[1];

endmodule

// File: rtl/crr_col_stepper.sv
module crr_col_stepper #(
  parameter int N_CHARS  = 8,
  parameter int CNT_W    = 10,
  parameter int BOX_LEFT = 457,
  localparam int SLOT_W  = (N_CHARS > 1) ? $clog2(N_CHARS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  h_cnt,
  output logic              in_span,
  output logic [SLOT_W-1:0] slot,
  output crr_pkg::cell_col_t col
);

  import crr_pkg::*;

  localparam logic [CNT_W-1:0] LEFT_V  = CNT_W'(BOX_LEFT);
  localparam logic [CNT_W-1:0] RIGHT_V = CNT_W'(BOX_LEFT + GLYPH_W * N_CHARS - 1);
  localparam cell_col_t        LAST_COL = cell_col_t'(GLYPH_W - 1);

  logic              at_left;
  logic              step_en;
  cell_col_t         col_q, col_d, col_cur;
  logic [SLOT_W-1:0] slot_q, slot_d, slot_cur;

  assign at_left = (h_cnt == LEFT_V);
  assign in_span = (h_cnt >= LEFT_V) && (h_cnt <= RIGHT_V);
  assign step_en = in_span;

  // Left edge reloads the position; elsewhere the stored position is current.
  always_comb begin
    col_cur  = at_left ? '0 : col_q;
    slot_cur = at_left ? '0 : slot_q;
  end

  always_comb begin
    col_d  = col_q;
    slot_d = slot_q;
    if (step_en) begin
      if (col_cur == LAST_COL) begin
        col_d  = '0;
        slot_d = slot_cur + 1'b1;
      end else begin
        col_d  = col_cur + 1'b1;
        slot_d = slot_cur;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q  <= '0;
      slot_q <= '0;
    end else if (step_en) begin
      col_q  <= col_d;
      slot_q <= slot_d;
    end
  end

  assign col  = col_cur;
  assign slot = slot_cur;

endmodule

// File: rtl/crr_code_store.sv
module crr_code_store #(
  parameter int N_CHARS = 8,
  parameter int ADDR_W  = 4,
  localparam int SLOT_W = (N_CHARS > 1) ? $clog2(N_CHARS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  crr_pkg::char_code_t wr_code,
  input  logic [SLOT_W-1:0]   rd_slot,
  output crr_pkg::char_code_t rd_code
);

  import crr_pkg::*;

  char_code_t codes_q [N_CHARS];

  for (genvar i = 0; i < N_CHARS; i++) begin : g_slot
    logic       slot_we;
    char_code_t slot_d;

    // Only an exact address match enables a slot, so high addresses hit nothing.
    assign slot_we = wr_en && (wr_addr == ADDR_W'(i));

    always_comb begin
      slot_d = codes_q[i];
      if (slot_we) begin
        slot_d = wr_code;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        codes_q[i] <= CODE_BLANK;
      end else if (slot_we) begin
        codes_q[i] <= slot_d;
      end
    end
  end

  always_comb begin
    rd_code = CODE_BLANK;
    for (int i = 0; i < N_CHARS; i++) begin
      if (rd_slot == SLOT_W'(i)) begin
        rd_code = codes_q[i];
      end
    end
  end

endmodule

// File: rtl/crr_glyph_lookup.sv
module crr_glyph_lookup (
  input  crr_pkg::char_code_t code,
  input  crr_pkg::cell_col_t  col,
  input  crr_pkg::cell_row_t  row,
  output logic                lit
);

  import crr_pkg::*;

  logic [39:0] body;
  logic [7:0]  col_word;

  assign body = glyph_body(code);

  // Outer columns are never stored: they are the gap between cells.
  always_comb begin
    case (col)
      3'd1:    col_word = body[39:32];
      3'd2:    col_word = body[31:24];
      3'd3:    col_word = body[23:16];
      3'd4:    col_word = body[15:8];
      3'd5:    col_word = body[7:0];
      default: col_word = 8'h00;
    endcase
  end

  assign lit = col_word[row];

endmodule

// File: rtl/crr_pixel_drive.sv
module crr_pixel_drive #(
  parameter int CNT_W      = 10,
  parameter int BOX_TOP    = 267,
  parameter int VIS_TOP    = 31,
  parameter int VIS_BOTTOM = 510,
  parameter int VIS_LEFT   = 144,
  parameter int VIS_RIGHT  = 783
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] h_cnt,
  input  logic [CNT_W-1:0] v_cnt,
  input  logic             in_span,
  input  logic             glyph_bit,
  output logic [7:0]       rgb
);

  import crr_pkg::*;

  localparam logic [CNT_W-1:0] TOP_V    = CNT_W'(BOX_TOP);
  localparam logic [CNT_W-1:0] BOTTOM_V = CNT_W'(BOX_TOP + GLYPH_H - 1);
  localparam logic [CNT_W-1:0] VT_V     = CNT_W'(VIS_TOP);
  localparam logic [CNT_W-1:0] VB_V     = CNT_W'(VIS_BOTTOM);
  localparam logic [CNT_W-1:0] VL_V     = CNT_W'(VIS_LEFT);
  localparam logic [CNT_W-1:0] VR_V     = CNT_W'(VIS_RIGHT);

  logic       visible;
  logic       in_rows;
  logic       show;
  logic [7:0] rgb_d;
  logic [7:0] rgb_q;

  assign visible = (v_cnt >= VT_V) && (v_cnt <= VB_V) &&
                   (h_cnt >= VL_V) && (h_cnt <= VR_V);
  assign in_rows = (v_cnt >= TOP_V) && (v_cnt <= BOTTOM_V);
  assign show    = visible && in_rows && in_span && glyph_bit;

  always_comb begin
    rgb_d = show ? 8'hFF : 8'h00;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rgb_q <= 8'h00;
    end else begin
      rgb_q <= rgb_d;
    end
  end

  assign rgb = rgb_q;

endmodule

// File: rtl/char_row_render.sv
module char_row_render #(
  parameter int N_CHARS    = 8,
  parameter int ADDR_W     = 4,
  parameter int CNT_W      = 10,
  parameter int BOX_LEFT   = 457,
  parameter int BOX_TOP    = 267,
  parameter int VIS_TOP    = 31,
  parameter int VIS_BOTTOM = 510,
  parameter int VIS_LEFT   = 144,
  parameter int VIS_RIGHT  = 783
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  h_cnt,
  input  logic [CNT_W-1:0]  v_cnt,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [5:0]        wr_code,
  output logic [2:0]        red,
  output logic [2:0]        grn,
  output logic [1:0]        blu
);

  import crr_pkg::*;

  localparam int SLOT_W = (N_CHARS > 1) ? $clog2(N_CHARS) : 1;
  localparam logic [CNT_W-1:0] TOP_V = CNT_W'(BOX_TOP);

  logic              rst_core_n;
  logic              in_span;
  logic [SLOT_W-1:0] cur_slot;
  cell_col_t         cur_col;
  cell_row_t         cur_row;
  char_code_t        cur_code;
  logic              glyph_bit;
  logic [7:0]        rgb;

  crr_reset_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_core_n (rst_core_n)
  );

  crr_col_stepper #(
    .N_CHARS  (N_CHARS),
    .CNT_W    (CNT_W),
    .BOX_LEFT (BOX_LEFT)
  ) u_step (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .h_cnt   (h_cnt),
    .in_span (in_span),
    .slot    (cur_slot),
    .col     (cur_col)
  );

  crr_code_store #(
    .N_CHARS (N_CHARS),
    .ADDR_W  (ADDR_W)
  ) u_store (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_code (wr_code),
    .rd_slot (cur_slot),
    .rd_code (cur_code)
  );

  assign cur_row = cell_row_t'(v_cnt - TOP_V);

  crr_glyph_lookup u_glyph (
    .code (cur_code),
    .col  (cur_col),
    .row  (cur_row),
    .lit  (glyph_bit)
  );

  crr_pixel_drive #(
    .CNT_W      (CNT_W),
    .BOX_TOP    (BOX_TOP),
    .VIS_TOP    (VIS_TOP),
    .VIS_BOTTOM (VIS_BOTTOM),
    .VIS_LEFT   (VIS_LEFT),
    .VIS_RIGHT  (VIS_RIGHT)
  ) u_drv (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .h_cnt     (h_cnt),
    .v_cnt     (v_cnt),
    .in_span   (in_span),
    .glyph_bit (glyph_bit),
    .rgb       (rgb)
  );

  assign red = rgb[7:5];
  assign grn = rgb[4:2];
  assign blu = rgb[1:0];

endmodule

// File: rtl/char_row_render_chk.sv
module char_row_render_chk #(
  parameter int N_CHARS    = 8,
  parameter int CNT_W      = 10,
  parameter int BOX_LEFT   = 457,
  parameter int BOX_TOP    = 267,
  parameter int VIS_TOP    = 31,
  parameter int VIS_BOTTOM = 510,
  parameter int VIS_LEFT   = 144,
  parameter int VIS_RIGHT  = 783
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] h_cnt,
  input logic [CNT_W-1:0] v_cnt,
  input logic [2:0]       red,
  input logic [2:0]       grn,
  input logic [1:0]       blu
);

  logic [7:0] colour;
  assign colour = {red, grn, blu};

  function automatic bit seen_visible(input int h, input int v);
    return (v >= VIS_TOP) && (v <= VIS_BOTTOM) && (h >= VIS_LEFT) && (h <= VIS_RIGHT);
  endfunction

  function automatic bit seen_in_strip(input int h, input int v);
    return (h >= BOX_LEFT) && (h < BOX_LEFT + 7 * N_CHARS) &&
           (v >= BOX_TOP) && (v < BOX_TOP + 8);
  endfunction

  function automatic bit seen_gap_col(input int h);
    int off;
    off = h - BOX_LEFT;
    return ((off % 7) == 0) || ((off % 7) == 6);
  endfunction

  a_r5_dark_outside_window: assert property (@(posedge clk) disable iff (!rst_n)
    !seen_visible(int'($past(h_cnt)), int'($past(v_cnt))) |-> (colour == 8'h00));

  a_r7_dark_outside_strip: assert property (@(posedge clk) disable iff (!rst_n)
    !seen_in_strip(int'($past(h_cnt)), int'($past(v_cnt))) |-> (colour == 8'h00));

  a_r2_gap_columns_dark: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_in_strip(int'($past(h_cnt)), int'($past(v_cnt))) &&
     seen_gap_col(int'($past(h_cnt)))) |-> (colour == 8'h00));

  a_r6_black_or_white: assert property (@(posedge clk) disable iff (!rst_n)
    (colour == 8'h00) || (colour == 8'hFF));

  always @(negedge clk) begin
    if (!rst_n) begin
      a_r8_reset_dark: assert (colour == 8'h00);
    end
  end

endmodule

bind char_row_render char_row_render_chk #(
  .N_CHARS    (N_CHARS),
  .CNT_W      (CNT_W),
  .BOX_LEFT   (BOX_LEFT),
  .BOX_TOP    (BOX_TOP),
  .VIS_TOP    (VIS_TOP),
  .VIS_BOTTOM (VIS_BOTTOM),
  .VIS_LEFT   (VIS_LEFT),
  .VIS_RIGHT  (VIS_RIGHT)
) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .h_cnt (h_cnt),
  .v_cnt (v_cnt),
  .red   (red),
  .grn   (grn),
  .blu   (blu)
);

// File: tb/char_row_render_tb_top.sv
module char_row_render_tb_top;

  localparam int NC = 8;
  localparam int AW = 4;
  localparam int CW = 10;
  localparam int L  = 140;  // strip straddles the visible left edge (144)
  localparam int T  = 30;   // row 0 lies on line 30, above the visible top (31)

  // {code, col, row, expected bit}
  localparam int NVEC = 15;
  localparam logic [12:0] VEC [NVEC] = '{
    {6'd1,  3'd2, 3'd1, 1'b1},
    {6'd1,  3'd2, 3'd2, 1'b0},
    {6'd1,  3'd3, 3'd4, 1'b1},
    {6'd1,  3'd4, 3'd6, 1'b1},
    {6'd1,  3'd4, 3'd5, 1'b0},
    {6'd10, 3'd1, 3'd1, 1'b1},
    {6'd10, 3'd3, 3'd4, 1'b1},
    {6'd10, 3'd3, 3'd3, 1'b0},
    {6'd10, 3'd6, 3'd1, 1'b0},
    {6'd17, 3'd3, 3'd3, 1'b1},
    {6'd62, 3'd3, 3'd3, 1'b0},
    {6'd63, 3'd2, 3'd2, 1'b1},
    {6'd63, 3'd1, 3'd2, 1'b0},
    {6'd40, 3'd3, 3'd1, 1'b1},
    {6'd50, 3'd1, 3'd2, 1'b1}
  };

  logic          clk;
  logic          rst_n;
  logic [CW-1:0] h_cnt;
  logic [CW-1:0] v_cnt;
  logic          wr_en;
  logic [AW-1:0] wr_addr;
  logic [5:0]    wr_code;
  logic [2:0]    red;
  logic [2:0]    grn;
  logic [1:0]    blu;

  int    n_checks;
  int    n_errors;
  bit    done;
  string ctx;
  logic [5:0] mdl [NC];

  char_row_render #(
    .N_CHARS  (NC),
    .ADDR_W   (AW),
    .CNT_W    (CW),
    .BOX_LEFT (L),
    .BOX_TOP  (T)
  ) dut_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .h_cnt   (h_cnt),
    .v_cnt   (v_cnt),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_code (wr_code),
    .red     (red),
    .grn     (grn),
    .blu     (blu)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Column words from the requirements (R3, R4), only for codes the bench uses.
  function automatic logic [7:0] spec_col(input logic [5:0] code, input int col);
    logic [39:0] b;
    if (col == 0 || col == 6) return 8'h00;  // R2
    case (code)
      6'd1:  b = 40'h00_42_7F_40_00;
      6'd10: b = 40'h7E_11_11_11_7E;
      6'd17: b = 40'h7F_08_08_08_7F;
      6'd21: b = 40'h7F_40_40_40_40;
      6'd62: b = 40'h0;
      6'd63: b = 40'h00_36_36_00_00;
      default: b = 40'h14_08_3E_08_14;
    endcase
    return b[(5 - col) * 8 +: 8];
  endfunction

  function automatic bit vis(input int h, input int v);
    return v >= 31 && v <= 510 && h >= 144 && h <= 783;
  endfunction

  function automatic bit inbox(input int h, input int v);
    return h >= L && h < L + 7 * NC && v >= T && v < T + 8;
  endfunction

  function automatic logic [7:0] expect_px(input int h, input int v);
    logic [7:0] w;
    if (!vis(h, v) || !inbox(h, v)) return 8'h00;
    w = spec_col(mdl[(h - L) / 7], (h - L) % 7);
    return w[v - T] ? 8'hFF : 8'h00;
  endfunction

  function automatic string req_of(input int h, input int v);
    if (!vis(h, v)) return "R5";
    if (!inbox(h, v)) return "R7";
    if (((h - L) % 7) == 0 || ((h - L) % 7) == 6) return "R2";
    return "R6";
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s: actual=%02h expected=%02h", req, ctx, act, exp);
    end
  endtask

  task automatic do_write(input int addr, input logic [5:0] code);
    wr_en   = 1'b1;
    wr_addr = AW'(addr);
    wr_code = code;
    @(negedge clk);
    wr_en   = 1'b0;
    if (addr < NC) mdl[addr] = code;  // R9: out-of-range writes leave the model alone
  endtask

  // Step the counter one pixel per clock; check each result after its edge (R8).
  task automatic scan_span(input int v, input int lo, input int hi);
    for (int h = lo; h <= hi; h++) begin
      h_cnt = CW'(h);
      v_cnt = CW'(v);
      @(negedge clk);
      chk(req_of(h, v), {red, grn, blu}, expect_px(h, v));
    end
  endtask

  initial begin
    int wd;
    for (wd = 0; wd < 150000 && !done; wd++) @(posedge clk);
    if (!done) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    n_checks = 0;
    n_errors = 0;
    done     = 1'b0;
    ctx      = "reset";
    for (int i = 0; i < NC; i++) mdl[i] = 6'd62;
    rst_n   = 1'b1;
    h_cnt   = CW'(L - 3);
    v_cnt   = CW'(T + 3);
    wr_en   = 1'b0;
    wr_addr = '0;
    wr_code = '0;
    #2 rst_n = 1'b0;

    // R8: held dark through reset
    repeat (3) begin
      @(negedge clk);
      chk("R8", {red, grn, blu}, 8'h00);
    end
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R9: all slots blank after reset
    ctx = "R9 blank after reset";
    scan_span(T + 3, L - 2, L + 7 * NC + 1);

    // Vector table: glyph bits for R1, R2, R3, R4 via slot 2
    for (int k = 0; k < NVEC; k++) begin
      logic [5:0] vc;
      int vcol, vrow;
      string tag;
      vc   = VEC[k][12:7];
      vcol = int'(VEC[k][6:4]);
      vrow = int'(VEC[k][3:1]);
      ctx  = $sformatf("R1 vector %0d", k);
      do_write(2, vc);
      scan_span(T + vrow, L - 2, L + 14 + vcol);
      if (vcol == 0 || vcol == 6) tag = "R2";
      else if (vc >= 6'd36) tag = "R4";
      else tag = "R3";
      chk(tag, {red, grn, blu}, VEC[k][0] ? 8'hFF : 8'h00);
      h_cnt = CW'(L - 3);
      @(negedge clk);
    end

    // Full strip, every line, lines consecutively (R10 restart at left edge)
    do_write(0, 6'd17);
    do_write(1, 6'd1);
    do_write(2, 6'd10);
    do_write(3, 6'd21);
    do_write(4, 6'd62);
    do_write(5, 6'd63);
    do_write(6, 6'd40);
    do_write(7, 6'd50);
    for (int v = T - 1; v <= T + 9; v++) begin
      ctx = $sformatf("R10 line %0d", v);
      scan_span(v, L - 3, L + 7 * NC + 2);
    end
    // R5: 'H' column 3 row 3 is set but lies at h=143, outside the window
    ctx = "R5 border";
    scan_span(T + 3, L - 1, L + 3);
    chk("R5", {red, grn, blu}, 8'h00);

    // R9 write timing: slot 2 'H' -> blank while its column 1 is being shown
    ctx = "R9 write timing";
    do_write(2, 6'd17);
    scan_span(T + 3, L - 2, L + 14);
    h_cnt = CW'(L + 15); wr_en = 1'b1; wr_addr = AW'(2); wr_code = 6'd62;
    @(negedge clk);
    chk("R9", {red, grn, blu}, 8'hFF);   // old code still used
    wr_en = 1'b0; mdl[2] = 6'd62;
    h_cnt = CW'(L + 16);
    @(negedge clk);
    chk("R9", {red, grn, blu}, 8'h00);   // new code from next cycle
    scan_span(T + 3, L + 17, L + 7 * NC + 1);

    // R9 out-of-range writes ignored
    do_write(8, 6'd63);
    do_write(15, 6'd63);
    do_write(10, 6'd63);
    ctx = "R9 out-of-range write";
    scan_span(T + 2, L - 2, L + 7 * NC + 1);
    scan_span(T + 4, L - 2, L + 7 * NC + 1);

    // R8 async reset mid-frame on a lit pixel (slot 3 'L' col1 row3)
    ctx = "R8 mid reset";
    scan_span(T + 3, L - 2, L + 22);
    chk("R8", {red, grn, blu}, 8'hFF);
    h_cnt = CW'(L - 3);
    #2 rst_n = 1'b0;
    #1 chk("R8", {red, grn, blu}, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    for (int i = 0; i < NC; i++) mdl[i] = 6'd62;
    ctx = "R9 blank after second reset";
    scan_span(T + 3, L - 2, L + 7 * NC + 1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule